// File: doc/BRIEF.md
# Read/Write Interleaving Memory Port Arbiter

This block shares one external memory command port between a read stream and a write stream. Each direction presents `NPRIO` request lanes, one per priority level, and each lane is a valid/ready stream of word requests in which a `last` flag closes a transfer. In every cycle the block grants at most one word. It reports the granted direction and lane on a single memory command output, and it pulses a per-direction done flag when the closing word of a transfer goes out.

When both directions have work, the block alternates between bursts: `RD_BURST` words of reads (16 by default), then `WR_BURST` words of writes (8 by default). Reads therefore receive two thirds of the grant slots, whatever priorities the lanes carry. Each change of direction costs `turn_cfg + 1` idle cycles. When only one direction has work it is served every cycle and never pays a penalty. Inside a direction the highest-numbered lane wins, but only at a transfer boundary. An open transfer keeps its lane until its last word, including across direction switches.

The controller has four states. `ST_IDLE` is held from reset until the first grant. `ST_RD` and `ST_WR` serve reads and writes. `ST_TURN` is the penalty window. The transitions are:
- IDLE to RD when a read is grantable, and IDLE to WR otherwise when a write is grantable.
- RD to TURN when the read burst completes while a write is waiting, or when no read is grantable while a write is.
- RD to WR directly when no read is grantable and `turn_cfg` is 0.
- WR to TURN and WR to RD under the mirror-image conditions.
- TURN to the target direction when the penalty counter reaches zero.

Top module: `rw_interleave_arb`

## Requirements
- R1: At most one word is granted per cycle, and only to a lane whose valid is high. `mem_cmd_valid` marks the grant, `mem_cmd_write` is 1 for a write grant and 0 for a read grant, and `mem_cmd_prio` carries the granted lane index.
- R2: With no transfer open in a direction, the valid lane with the highest index is granted first.
- R3: Once a word with `last`=0 is granted on a lane, that direction grants no other lane until that lane's word with `last`=1 is granted. Requests on one lane are therefore served strictly in order.
- R4: When both directions are pending without pause, grants follow a repeating pattern of `RD_BURST` reads then `WR_BURST` writes (a 2:1 split at default), regardless of which lanes are valid.
- R5: Between the last grant of one direction and the first grant of the other there are exactly `turn_cfg`+1 cycles without a grant, when the new direction stays pending (`turn_cfg` 0..3 selects 1..4 cycles).
- R6: When only one direction has pending words, it is granted every cycle with no idle cycle and no forced switch beyond the burst length.
- R7: When the served direction has no grantable word and the other direction has one, the block switches at once, without waiting for the burst to finish, and still pays the R5 penalty.
- R8: `rd_done` (`wr_done`) is high exactly in the cycle in which a read (write) word with `last`=1 is granted.
- R9: During and right after reset nothing is granted and both done flags are low. The first grant after reset pays no penalty and is issued in the cycle its request is first valid.
- R10: A transfer cut by a direction switch resumes on the same lane when its direction returns, ahead of higher-priority lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turn_cfg | input | 2 | Turnaround penalty minus one |
| rd_valid | input | NPRIO | Read lane has a word request |
| rd_last | input | NPRIO | Read lane word closes its transfer |
| rd_ready | output | NPRIO | Read lane word granted this cycle |
| wr_valid | input | NPRIO | Write lane has a word request |
| wr_last | input | NPRIO | Write lane word closes its transfer |
| wr_ready | output | NPRIO | Write lane word granted this cycle |
| mem_cmd_valid | output | 1 | A word is issued to memory this cycle |
| mem_cmd_write | output | 1 | 1 = write word, 0 = read word |
| mem_cmd_prio | output | PW | Lane index of the issued word |
| rd_done | output | 1 | Read transfer completed this cycle |
| wr_done | output | 1 | Write transfer completed this cycle |

## Verification
The bench measures grant counts over whole burst periods for several penalty settings and lane mixes. A design that let priority sway the direction split, or that charged the penalty while only one direction was active, would show different counts. It also times the gap when the read stream runs dry mid-burst. A design that waited out the burst, or that counted the detecting cycle on top of the penalty, would issue its first write a cycle late or not at all. Other directed cases open a transfer and then raise a higher-priority lane, both within one direction and across a direction switch. A design that preempted at word level, or that dropped the lane lock while the other direction ran, would grant the wrong lane and complete the transfer at the wrong cycle.

// File: rtl/rwia_pkg.sv
package rwia_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_TURN = 2'd3
    } arb_state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

endpackage

// File: rtl/rwia_lane_pick.sv
// Per-direction lane selection with a transfer lock.
module rwia_lane_pick #(
    parameter int NPRIO = 4,
    localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPRIO-1:0] lane_valid,
    input  logic [NPRIO-1:0] lane_last,
    input  logic             serve,
    output logic             has_word,
    output logic [PW-1:0]    pick_idx,
    output logic [NPRIO-1:0] lane_ready,
    output logic             xfer_done
);

    logic          open_q;
    logic [PW-1:0] open_idx_q;
    logic [PW-1:0] hi_idx;
    logic          hi_any;
    logic          fire;

    // highest-index valid lane wins
    always_comb begin
        hi_idx = '0;
        hi_any = 1'b0;
        for (int i = 0; i < NPRIO; i++) begin
            if (lane_valid[i]) begin
                hi_idx = PW'(i);
                hi_any = 1'b1;
            end
        end
    end

    always_comb begin
        if (open_q) begin
            pick_idx = open_idx_q;
            has_word = lane_valid[open_idx_q];
        end else begin
            pick_idx = hi_idx;
            has_word = hi_any;
        end
    end

    assign fire      = serve && has_word;
    assign xfer_done = fire && lane_last[pick_idx];

    for (genvar g = 0; g < NPRIO; g++) begin : g_ready
        assign lane_ready[g] = fire && (pick_idx == PW'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            open_idx_q <= '0;
        end else if (fire) begin
            open_q     <= !lane_last[pick_idx];
            open_idx_q <= pick_idx;
        end
    end

endmodule

// File: rtl/rwia_turn_fsm.sv
// Direction state machine: burst counting and turnaround penalty.
module rwia_turn_fsm
    import rwia_pkg::*;
#(
    parameter int RD_BURST = 16,
    parameter int WR_BURST = 8,
    localparam int BMAX = (RD_BURST > WR_BURST) ? RD_BURST : WR_BURST,
    localparam int BW   = $clog2(BMAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] turn_cfg,
    input  logic       rd_has,
    input  logic       wr_has,
    output logic       rd_serve,
    output logic       wr_serve
);

    localparam logic [BW-1:0] RD_LIM = BW'(RD_BURST);
    localparam logic [BW-1:0] WR_LIM = BW'(WR_BURST);

    arb_state_e    st_q, st_n;
    dir_e          tgt_q, tgt_n;
    logic [BW-1:0] cnt_q, cnt_n;
    logic [1:0]    tc_q, tc_n;
    logic [BW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + BW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            tgt_q <= DIR_RD;
            cnt_q <= '0;
            tc_q  <= '0;
        end else begin
            st_q  <= st_n;
            tgt_q <= tgt_n;
            cnt_q <= cnt_n;
            tc_q  <= tc_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n     = st_q;
        tgt_n    = tgt_q;
        cnt_n    = cnt_q;
        tc_n     = tc_q;
        rd_serve = 1'b0;
        wr_serve = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (rd_has) begin
                    rd_serve = 1'b1;
                    st_n     = ST_RD;
                    cnt_n    = BW'(1);
                end else if (wr_has) begin
                    wr_serve = 1'b1;
                    st_n     = ST_WR;
                    cnt_n    = BW'(1);
                end
            end
            ST_RD: begin
                if (rd_has) begin
                    rd_serve = 1'b1;
                    if (cnt_inc >= RD_LIM) begin
                        cnt_n = '0;
                        if (wr_has) begin
                            st_n  = ST_TURN;
                            tgt_n = DIR_WR;
                            tc_n  = turn_cfg;
                        end
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end else if (wr_has) begin
                    // this idle cycle is the first penalty cycle
                    cnt_n = '0;
                    tgt_n = DIR_WR;
                    if (turn_cfg == 2'd0) begin
                        st_n = ST_WR;
                    end else begin
                        st_n = ST_TURN;
                        tc_n = turn_cfg - 2'd1;
                    end
                end
            end
            ST_WR: begin
                if (wr_has) begin
                    wr_serve = 1'b1;
                    if (cnt_inc >= WR_LIM) begin
                        cnt_n = '0;
                        if (rd_has) begin
                            st_n  = ST_TURN;
                            tgt_n = DIR_RD;
                            tc_n  = turn_cfg;
                        end
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end else if (rd_has) begin
                    cnt_n = '0;
                    tgt_n = DIR_RD;
                    if (turn_cfg == 2'd0) begin
                        st_n = ST_RD;
                    end else begin
                        st_n = ST_TURN;
                        tc_n = turn_cfg - 2'd1;
                    end
                end
            end
            ST_TURN: begin
                if (tc_q == 2'd0) begin
                    st_n = (tgt_q == DIR_WR) ? ST_WR : ST_RD;
                end else begin
                    tc_n = tc_q - 2'd1;
                end
            end
        endcase
    end

endmodule

// File: rtl/rw_interleave_arb.sv
// Top: two lane pickers and the direction state machine.
module rw_interleave_arb #(
    parameter int NPRIO    = 4,
    parameter int RD_BURST = 16,
    parameter int WR_BURST = 8,
    localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       turn_cfg,
    input  logic [NPRIO-1:0] rd_valid,
    input  logic [NPRIO-1:0] rd_last,
    output logic [NPRIO-1:0] rd_ready,
    input  logic [NPRIO-1:0] wr_valid,
    input  logic [NPRIO-1:0] wr_last,
    output logic [NPRIO-1:0] wr_ready,
    output logic             mem_cmd_valid,
    output logic             mem_cmd_write,
    output logic [PW-1:0]    mem_cmd_prio,
    output logic             rd_done,
    output logic             wr_done
);

    logic [1:0][NPRIO-1:0] lv, ll, lr;
    logic [1:0][PW-1:0]    pidx;
    logic [1:0]            has, serve, done;

    assign lv[0] = rd_valid;
    assign lv[1] = wr_valid;
    assign ll[0] = rd_last;
    assign ll[1] = wr_last;

    for (genvar d = 0; d < 2; d++) begin : g_dir
        rwia_lane_pick #(.NPRIO(NPRIO)) u_pick (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_valid(lv[d]),
            .lane_last (ll[d]),
            .serve     (serve[d]),
            .has_word  (has[d]),
            .pick_idx  (pidx[d]),
            .lane_ready(lr[d]),
            .xfer_done (done[d])
        );
    end

    rwia_turn_fsm #(.RD_BURST(RD_BURST), .WR_BURST(WR_BURST)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .turn_cfg(turn_cfg),
        .rd_has  (has[0]),
        .wr_has  (has[1]),
        .rd_serve(serve[0]),
        .wr_serve(serve[1])
    );

    assign rd_ready      = lr[0];
    assign wr_ready      = lr[1];
    assign rd_done       = done[0];
    assign wr_done       = done[1];
    assign mem_cmd_valid = |lr;
    assign mem_cmd_write = |lr[1];
    assign mem_cmd_prio  = (|lr[1]) ? pidx[1] : ((|lr[0]) ? pidx[0] : '0);

endmodule

// File: rtl/rw_interleave_arb_chk.sv
// Assertion checker, bound to the top module.
module rw_interleave_arb_chk #(
    parameter int NPRIO = 4,
    localparam int PW = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       turn_cfg,
    input logic [NPRIO-1:0] rd_valid,
    input logic [NPRIO-1:0] rd_last,
    input logic [NPRIO-1:0] rd_ready,
    input logic [NPRIO-1:0] wr_valid,
    input logic [NPRIO-1:0] wr_last,
    input logic [NPRIO-1:0] wr_ready,
    input logic             mem_cmd_valid,
    input logic             mem_cmd_write,
    input logic [PW-1:0]    mem_cmd_prio,
    input logic             rd_done,
    input logic             wr_done
);

    logic [3:0]    idle_cnt;
    logic          seen_q;
    logic          last_dir_q;
    logic          rd_open_q, wr_open_q;
    logic [PW-1:0] rd_lane_q, wr_lane_q;
    logic [3:0]    need_gap;

    assign need_gap = {2'b00, turn_cfg} + 4'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt   <= '0;
            seen_q     <= 1'b0;
            last_dir_q <= 1'b0;
            rd_open_q  <= 1'b0;
            wr_open_q  <= 1'b0;
            rd_lane_q  <= '0;
            wr_lane_q  <= '0;
        end else if (mem_cmd_valid) begin
            idle_cnt   <= '0;
            seen_q     <= 1'b1;
            last_dir_q <= mem_cmd_write;
            if (mem_cmd_write) begin
                wr_open_q <= !wr_last[mem_cmd_prio];
                wr_lane_q <= mem_cmd_prio;
            end else begin
                rd_open_q <= !rd_last[mem_cmd_prio];
                rd_lane_q <= mem_cmd_prio;
            end
        end else if (idle_cnt != 4'hf) begin
            idle_cnt <= idle_cnt + 4'd1;
        end
    end

    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_ready, wr_ready}));

    a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ready & ~rd_valid) == '0) && ((wr_ready & ~wr_valid) == '0));

    a_r3_rd_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_write && rd_open_q) |-> (mem_cmd_prio == rd_lane_q));

    a_r3_wr_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && mem_cmd_write && wr_open_q) |-> (mem_cmd_prio == wr_lane_q));

    a_r5_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && seen_q && (mem_cmd_write != last_dir_q)) |-> (idle_cnt >= need_gap));

    a_r8_rd_done: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (mem_cmd_valid && !mem_cmd_write && rd_last[mem_cmd_prio]));

    a_r8_wr_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (mem_cmd_valid && mem_cmd_write && wr_last[mem_cmd_prio]));

endmodule

bind rw_interleave_arb rw_interleave_arb_chk #(.NPRIO(NPRIO)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .turn_cfg     (turn_cfg),
    .rd_valid     (rd_valid),
    .rd_last      (rd_last),
    .rd_ready     (rd_ready),
    .wr_valid     (wr_valid),
    .wr_last      (wr_last),
    .wr_ready     (wr_ready),
    .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_write(mem_cmd_write),
    .mem_cmd_prio (mem_cmd_prio),
    .rd_done      (rd_done),
    .wr_done      (wr_done)
);

// File: tb/rw_interleave_arb_test.sv
`timescale 1ns/1ps
module rw_interleave_arb_test;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    turn_cfg = 2'd0;
    logic [NP-1:0] rd_valid = '0, rd_last = '0, wr_valid = '0, wr_last = '0;
    logic [NP-1:0] rd_ready, wr_ready;
    logic          mem_cmd_valid, mem_cmd_write, rd_done, wr_done;
    logic [1:0]    mem_cmd_prio;

    int tests = 0;
    int fails = 0;

    // lane model: rem -1 = endless, xl = words per transfer, st = first valid cycle
    int rem [2][NP];
    int wc  [2][NP];
    int xl  [2][NP];
    int st  [2][NP];
    int cyc;
    int tr_dir [256];
    int tr_pri [256];
    int tr_rdn [256];
    int tr_wdn [256];

    // turn_cfg, rd lane mask, wr lane mask, cycles, expected reads, expected writes
    localparam int VEC [5][6] = '{
        '{0, 15, 15, 52, 32, 16},
        '{3,  1,  8, 64, 32, 16},
        '{1,  0,  2, 40,  0, 40},
        '{2,  4,  0, 40, 40,  0},
        '{1,  8,  1, 56, 32, 16}
    };

    always #4 clk = ~clk;

    rw_interleave_arb #(.NPRIO(NP), .RD_BURST(16), .WR_BURST(8)) uut (
        .clk(clk), .rst_n(rst_n), .turn_cfg(turn_cfg),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_cmd_prio(mem_cmd_prio), .rd_done(rd_done), .wr_done(wr_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_valid = '0; wr_valid = '0; rd_last = '0; wr_last = '0;
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < NP; l++) begin
                rem[d][l] = 0; wc[d][l] = 0; xl[d][l] = 1; st[d][l] = 0;
            end
        for (int i = 0; i < 256; i++) begin
            tr_dir[i] = 0; tr_pri[i] = 0; tr_rdn[i] = 0; tr_wdn[i] = 0;
        end
        cyc = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        for (int l = 0; l < NP; l++) begin
            rd_valid[l] = (rem[0][l] != 0) && (cyc >= st[0][l]);
            wr_valid[l] = (rem[1][l] != 0) && (cyc >= st[1][l]);
            rd_last[l]  = (wc[0][l] % xl[0][l]) == xl[0][l] - 1;
            wr_last[l]  = (wc[1][l] % xl[1][l]) == xl[1][l] - 1;
        end
        #1;
        if (cyc < 256) begin
            tr_dir[cyc] = mem_cmd_valid ? (mem_cmd_write ? 2 : 1) : 0;
            tr_pri[cyc] = int'(mem_cmd_prio);
            tr_rdn[cyc] = int'(rd_done);
            tr_wdn[cyc] = int'(wr_done);
        end
        for (int l = 0; l < NP; l++) begin
            if (rd_ready[l]) begin wc[0][l]++; if (rem[0][l] > 0) rem[0][l]--; end
            if (wr_ready[l]) begin wc[1][l]++; if (rem[1][l] > 0) rem[1][l]--; end
        end
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int nr, nw, first_wr, idle;

        // vector table: direction split (R4), single direction (R6)
        for (int v = 0; v < 5; v++) begin
            turn_cfg = 2'(VEC[v][0]);
            do_reset();
            for (int l = 0; l < NP; l++) begin
                rem[0][l] = VEC[v][1][l] ? -1 : 0;
                rem[1][l] = VEC[v][2][l] ? -1 : 0;
                xl[0][l] = 4; xl[1][l] = 4;
            end
            for (int c = 0; c < VEC[v][3]; c++) step();
            nr = 0; nw = 0;
            for (int c = 0; c < VEC[v][3]; c++) begin
                if (tr_dir[c] == 1) nr++;
                if (tr_dir[c] == 2) nw++;
            end
            chk($sformatf("R4/R6 vec%0d reads", v), nr, VEC[v][4]);
            chk($sformatf("R4/R6 vec%0d writes", v), nw, VEC[v][5]);
        end

        // R9: reset state
        turn_cfg = 2'd0;
        do_reset();
        #1;
        chk("R9 reset mem_cmd_valid", int'(mem_cmd_valid), 0);
        chk("R9 reset done", int'(rd_done | wr_done), 0);
        chk("R9 reset ready", int'(|{rd_ready, wr_ready}), 0);

        // R2: highest lane first; R9: first grant in cycle 0
        do_reset();
        rem[0][1] = 1; rem[0][3] = 1;
        for (int c = 0; c < 4; c++) step();
        chk("R9 first grant cycle0", tr_dir[0], 1);
        chk("R2 highest lane first", tr_pri[0], 3);
        chk("R2 lower lane next", tr_pri[1], 1);

        // R3, R8: open transfer holds its lane
        do_reset();
        rem[0][0] = 3; xl[0][0] = 3;
        rem[0][3] = 1; st[0][3] = 1;
        for (int c = 0; c < 6; c++) step();
        chk("R3 locked lane cycle1", tr_pri[1], 0);
        chk("R3 locked lane cycle2", tr_pri[2], 0);
        chk("R3 high lane after close", tr_pri[3], 3);
        chk("R8 done on last word", tr_rdn[2], 1);
        chk("R8 no done mid transfer", tr_rdn[1], 0);

        // R5, R7: read stream runs dry mid-burst, penalty 3
        turn_cfg = 2'd2;
        do_reset();
        rem[0][0] = 3;
        rem[1][0] = -1;
        for (int c = 0; c < 10; c++) step();
        first_wr = -1;
        for (int c = 9; c >= 0; c--) if (tr_dir[c] == 2) first_wr = c;
        idle = 0;
        for (int c = 3; c < 6; c++) if (tr_dir[c] == 0) idle++;
        chk("R7 early switch first write", first_wr, 6);
        chk("R5 penalty idle cycles", idle, 3);

        // R5: penalty 1 at burst end; R10: lock survives a switch
        turn_cfg = 2'd0;
        do_reset();
        rem[0][0] = -1; xl[0][0] = 20;
        rem[0][2] = -1; st[0][2] = 5;
        rem[1][0] = -1;
        for (int c = 0; c < 34; c++) step();
        chk("R5 idle after burst", tr_dir[16], 0);
        chk("R5 write after one idle", tr_dir[17], 2);
        chk("R10 resume dir", tr_dir[26], 1);
        chk("R10 resume lane", tr_pri[26], 0);
        chk("R10 done at close", tr_rdn[29], 1);
        chk("R10 high lane after close", tr_pri[30], 2);

        summary();
    end

endmodule